// File: doc/BRIEF.md
# Multiplexed LCD scan controller

This block keeps an 80-column by 4-row on/off bitmap and turns it into a digital model of the drive seen by a segment LCD: four backplane outputs and eighty segment outputs, each carrying a 2-bit level code for the current time slot. A host fills the bitmap through a simple write port: a column address, a row, a data bit and a write strobe. It picks one of four multiplex ratios on a 2-bit mode input.

A frame tick input moves the scan to the next time slot. The number of slots in a frame follows the mode. Every other frame is driven with inverted polarity, so the drive averages to zero. In the reduced modes the unused backplanes copy the used ones, so a board can tie them together for more drive strength. Analog levels, bias, host serial protocols and pads sit outside this block. The codes stand for drive states, not voltages.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset the slot is 0, the polarity is 0, the mode is static and the bitmap is all zero. Every backplane therefore outputs 2'b01 and every segment outputs 2'b00.
- R2: The mode is coded as 00 static, 01 for 1:2, 10 for 1:3 and 11 for 1:4. A frame holds 1, 2, 3 or 4 slots, and each frame tick moves to the next slot, wrapping to slot 0 after the last one.
- R3: A level code is {pol, active ^ pol}, where pol is the frame polarity. Every output carries the same pol. pol toggles on the tick that wraps the slot back to 0.
- R4: In 1:4 mode, backplane b is active (selected) only in slot b.
- R5: In 1:3 mode, backplanes 0, 1 and 2 are active in slots 0, 1 and 2. Backplane 3 always equals backplane 1.
- R6: In 1:2 mode, backplane 2 always equals backplane 0 and backplane 3 equals backplane 1. Backplanes 0 and 1 are active in slots 0 and 1.
- R7: In static mode, all four backplanes are active in every frame.
- R8: Segment n is active (on) in slot s exactly when bitmap row s, column n holds 1. In static mode row 0 is used.
- R9: A bitmap write shows on the segments only from the next frame tick onward. A write in the same cycle as a tick does not enter that slot. With no tick, all outputs hold their value.
- R10: A write with a column address of 80 or more changes nothing.
- R11: mode_i is sampled only on a frame tick. The wrap is decided against the new mode. If the slot is at or past the new mode's last slot, the slot goes to 0 and pol toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Multiplex mode, sampled on a frame tick |
| frame_tick_i | input | 1 | Advance to the next time slot |
| wr_en_i | input | 1 | Bitmap write strobe |
| wr_col_i | input | 7 | Bitmap column address |
| wr_row_i | input | 2 | Bitmap row |
| wr_data_i | input | 1 | Bit to store, 1 = element on |
| bp_lvl_o | output | 8 | Backplane level codes, backplane b at [2b+1:2b] |
| seg_lvl_o | output | 160 | Segment level codes, segment n at [2n+1:2n] |

## Verification
The bench builds the block with the default 80 columns and a 7-bit column address. This leaves the addresses 80 to 127 free to drive, which exercises the out-of-range write guard. Random stimulus covers several thousand cycles. In that stream, ticks and mode switches arrive at arbitrary slot positions, so mid-frame switches to a shorter mode occur at every slot index. Writes also coincide with ticks, which checks that the segment data is loaded at the slot boundary.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'b00,
    MUX_2      = 2'b01,
    MUX_3      = 2'b10,
    MUX_4      = 2'b11
  } mux_mode_e;

  localparam int unsigned NUM_BP = 4;
  localparam int unsigned ROW_W  = 2;
  localparam int unsigned LVL_W  = 2;

  // index of the last slot in a frame
  function automatic logic [ROW_W-1:0] last_slot(mux_mode_e m);
    return ROW_W'(m);
  endfunction

  // bitmap row served by a backplane in a given mode
  function automatic logic [ROW_W-1:0] bp_row(mux_mode_e m, logic [ROW_W-1:0] b);
    logic [ROW_W-1:0] r;
    case (m)
      MUX_STATIC: r = '0;
      MUX_2:      r = {1'b0, b[0]};
      MUX_3:      r = (b == 2'd3) ? 2'd1 : b;
      default:    r = b;
    endcase
    return r;
  endfunction

  function automatic logic [LVL_W-1:0] lvl_code(logic active, logic pol);
    return {pol, active ^ pol};
  endfunction

endpackage

// File: rtl/lcd_bitmap.sv
module lcd_bitmap
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COLS = 80,
  parameter int unsigned NUM_ROWS = 4,
  localparam int unsigned COL_W   = $clog2(NUM_COLS),
  localparam int unsigned RW      = $clog2(NUM_ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [COL_W-1:0]    wr_col_i,
  input  logic [RW-1:0]       wr_row_i,
  input  logic                wr_data_i,
  input  logic [RW-1:0]       rd_row_i,
  output logic [NUM_COLS-1:0] rd_bits_o
);

  logic [NUM_ROWS-1:0][NUM_COLS-1:0] rows_w;
  logic                              col_ok;

  assign col_ok = (32'(wr_col_i) < NUM_COLS);

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic [NUM_COLS-1:0] row_q;
    logic                hit;
    assign hit = wr_en_i && col_ok && (wr_row_i == RW'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  row_q <= '0;
      else if (hit) row_q[wr_col_i] <= wr_data_i;
    end
    assign rows_w[r] = row_q;
  end

  assign rd_bits_o = rows_w[rd_row_i];

endmodule

// File: rtl/lcd_slot_seq.sv
module lcd_slot_seq
  import lcd_scan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_tick_i,
  input  logic [1:0]       mode_i,
  output mux_mode_e        mode_o,
  output logic [ROW_W-1:0] slot_o,
  output logic [ROW_W-1:0] nxt_slot_o,
  output logic             pol_o
);

  mux_mode_e        mode_q, mode_new;
  logic [ROW_W-1:0] slot_q;
  logic             pol_q, wrap;

  assign mode_new   = mux_mode_e'(mode_i);
  // wrap is judged against the mode being loaded
  assign wrap       = (slot_q >= last_slot(mode_new));
  assign nxt_slot_o = wrap ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MUX_STATIC;
      slot_q <= '0;
      pol_q  <= 1'b0;
    end else if (frame_tick_i) begin
      mode_q <= mode_new;
      slot_q <= nxt_slot_o;
      pol_q  <= pol_q ^ wrap;
    end
  end

  assign mode_o = mode_q;
  assign slot_o = slot_q;
  assign pol_o  = pol_q;

endmodule

// File: rtl/lcd_level_gen.sv
module lcd_level_gen
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COLS = 80
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [NUM_COLS-1:0]       row_bits_i,
  input  mux_mode_e                 mode_i,
  input  logic [ROW_W-1:0]          slot_i,
  input  logic                      pol_i,
  output logic [NUM_BP*LVL_W-1:0]   bp_lvl_o,
  output logic [NUM_COLS*LVL_W-1:0] seg_lvl_o
);

  logic [NUM_COLS-1:0] shadow_q;

  // segment data latched at the slot boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (load_i) shadow_q <= row_bits_i;
  end

  for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
    logic sel;
    assign sel = (bp_row(mode_i, ROW_W'(b)) == slot_i);
    assign bp_lvl_o[b*LVL_W +: LVL_W] = lvl_code(sel, pol_i);
  end

  for (genvar n = 0; n < NUM_COLS; n++) begin : g_seg
    assign seg_lvl_o[n*LVL_W +: LVL_W] = lvl_code(shadow_q[n], pol_i);
  end

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COLS = 80,
  localparam int unsigned COL_W   = $clog2(NUM_COLS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                mode_i,
  input  logic                      frame_tick_i,
  input  logic                      wr_en_i,
  input  logic [COL_W-1:0]          wr_col_i,
  input  logic [ROW_W-1:0]          wr_row_i,
  input  logic                      wr_data_i,
  output logic [NUM_BP*LVL_W-1:0]   bp_lvl_o,
  output logic [NUM_COLS*LVL_W-1:0] seg_lvl_o
);

  mux_mode_e           act_mode;
  logic [ROW_W-1:0]    act_slot, nxt_slot;
  logic                act_pol;
  logic [NUM_COLS-1:0] row_bits;

  lcd_slot_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_tick_i (frame_tick_i),
    .mode_i       (mode_i),
    .mode_o       (act_mode),
    .slot_o       (act_slot),
    .nxt_slot_o   (nxt_slot),
    .pol_o        (act_pol)
  );

  lcd_bitmap #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_BP)) u_bitmap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_col_i  (wr_col_i),
    .wr_row_i  (wr_row_i),
    .wr_data_i (wr_data_i),
    .rd_row_i  (nxt_slot),
    .rd_bits_o (row_bits)
  );

  lcd_level_gen #(.NUM_COLS(NUM_COLS)) u_lvl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (frame_tick_i),
    .row_bits_i (row_bits),
    .mode_i     (act_mode),
    .slot_i     (act_slot),
    .pol_i      (act_pol),
    .bp_lvl_o   (bp_lvl_o),
    .seg_lvl_o  (seg_lvl_o)
  );

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COLS = 80
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      frame_tick_i,
  input logic [1:0]                act_mode,
  input logic [ROW_W-1:0]          act_slot,
  input logic [NUM_BP*LVL_W-1:0]   bp_lvl_o,
  input logic [NUM_COLS*LVL_W-1:0] seg_lvl_o
);

  logic [NUM_BP-1:0]   bp_act, bp_pol;
  logic [NUM_COLS-1:0] seg_pol;
  logic [LVL_W-1:0]    bp0, bp1, bp2, bp3;

  for (genvar b = 0; b < NUM_BP; b++) begin : g_b
    assign bp_act[b] = bp_lvl_o[b*LVL_W] ^ bp_lvl_o[b*LVL_W+1];
    assign bp_pol[b] = bp_lvl_o[b*LVL_W+1];
  end
  for (genvar n = 0; n < NUM_COLS; n++) begin : g_n
    assign seg_pol[n] = seg_lvl_o[n*LVL_W+1];
  end
  assign bp0 = bp_lvl_o[0 +: LVL_W];
  assign bp1 = bp_lvl_o[LVL_W +: LVL_W];
  assign bp2 = bp_lvl_o[2*LVL_W +: LVL_W];
  assign bp3 = bp_lvl_o[3*LVL_W +: LVL_W];

  a_r2_slot_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_slot <= act_mode);

  a_r3_common_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_pol == {NUM_BP{bp_pol[0]}}) && (seg_pol == {NUM_COLS{bp_pol[0]}}));

  a_r4_single_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_mode == 2'b11 |-> $countones(bp_act) == 1);

  a_r5_bp3_copies_bp1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_mode == 2'b10 |-> bp3 == bp1 && $countones(bp_act[2:0]) == 1);

  a_r6_pairs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_mode == 2'b01 |-> bp2 == bp0 && bp3 == bp1 && bp0 != bp1);

  a_r7_static_all_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_mode == 2'b00 |-> &bp_act);

  a_r9_seg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i |=> $stable(seg_lvl_o));

  a_r9_bp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i |=> $stable(bp_lvl_o));

endmodule

bind lcd_scan_ctrl lcd_scan_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_tick_i (frame_tick_i),
  .act_mode     (act_mode),
  .act_slot     (act_slot),
  .bp_lvl_o     (bp_lvl_o),
  .seg_lvl_o    (seg_lvl_o)
);

// File: tb/lcd_scan_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_scan_ctrl_tb;

  localparam int NC = 80;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         tick = 1'b0;
  logic         wr = 1'b0;
  logic [6:0]   col = '0;
  logic [1:0]   row = '0;
  logic         dat = 1'b0;
  logic [7:0]   bp;
  logic [159:0] seg;

  int checks = 0;
  int errors = 0;

  // model state
  logic [NC-1:0] m_row [4];
  logic [NC-1:0] m_shadow;
  logic [1:0]    m_slot, m_mode;
  logic          m_pol;

  always #10 clk = ~clk;

  lcd_scan_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .frame_tick_i(tick),
    .wr_en_i(wr), .wr_col_i(col), .wr_row_i(row), .wr_data_i(dat),
    .bp_lvl_o(bp), .seg_lvl_o(seg)
  );

  function automatic logic bp_sel(int b);
    case (m_mode)
      2'b00:   return 1'b1;
      2'b01:   return (b % 2) == m_slot;
      2'b10:   return ((b == 3) ? 1 : b) == m_slot;
      default: return b == m_slot;
    endcase
  endfunction

  function automatic logic [7:0] exp_bp();
    logic [7:0] v;
    for (int b = 0; b < 4; b++) v[2*b +: 2] = {m_pol, bp_sel(b) ^ m_pol};
    return v;
  endfunction

  function automatic logic [159:0] exp_seg();
    logic [159:0] v;
    for (int n = 0; n < NC; n++) v[2*n +: 2] = {m_pol, m_shadow[n] ^ m_pol};
    return v;
  endfunction

  task automatic check(string tag);
    checks++;
    if (bp !== exp_bp()) begin
      errors++;
      $display("FAIL %s backplane: actual %h expected %h", tag, bp, exp_bp());
    end
    checks++;
    if (seg !== exp_seg()) begin
      errors++;
      $display("FAIL %s segments: actual %h expected %h", tag, seg, exp_seg());
    end
  endtask

  task automatic model_step(logic t, logic [1:0] md, logic w, logic [6:0] c,
                            logic [1:0] r, logic d);
    logic wrap;
    logic [1:0] nx;
    if (t) begin
      wrap     = (m_slot >= md);
      nx       = wrap ? 2'd0 : m_slot + 2'd1;
      m_shadow = m_row[nx];
      m_slot   = nx;
      m_mode   = md;
      m_pol    = m_pol ^ wrap;
    end
    if (w && int'(c) < NC) m_row[r][c] = d;
  endtask

  task automatic cyc(logic t, logic [1:0] md, logic w, logic [6:0] c,
                     logic [1:0] r, logic d, string tag);
    @(negedge clk);
    tick = t; mode = md; wr = w; col = c; row = r; dat = d;
    @(posedge clk);
    #1;
    model_step(t, md, w, c, r, d);
    check(tag);
  endtask

  task automatic ticks(int n, logic [1:0] md, string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, md, 1'b0, '0, '0, 1'b0, tag);
  endtask

  initial begin
    for (int r = 0; r < 4; r++) m_row[r] = '0;
    m_shadow = '0; m_slot = '0; m_mode = '0; m_pol = 1'b0;
    void'($urandom(32'h5eed_1cd0));
    #45 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");

    // static: all selected, polarity flips every tick
    ticks(3, 2'b00, "R7 static");
    cyc(1'b0, 2'b00, 1'b1, 7'd3, 2'd0, 1'b1, "R9 write without tick");
    ticks(2, 2'b00, "R8 static row 0");

    // 1:4 pattern
    cyc(1'b0, 2'b11, 1'b1, 7'd0,  2'd0, 1'b1, "R9 hold");
    cyc(1'b0, 2'b11, 1'b1, 7'd5,  2'd1, 1'b1, "R9 hold");
    cyc(1'b0, 2'b11, 1'b1, 7'd79, 2'd2, 1'b1, "R9 hold");
    cyc(1'b0, 2'b11, 1'b1, 7'd40, 2'd3, 1'b1, "R11 mode needs tick");
    ticks(8, 2'b11, "R4 R8 1:4 scan");

    // out of range columns
    for (int c = NC; c < 128; c += 7)
      cyc(1'b0, 2'b11, 1'b1, 7'(c), 2'(c % 4), 1'b1, "R10 out of range");
    ticks(4, 2'b11, "R10 after ignored writes");

    // write together with tick
    cyc(1'b1, 2'b11, 1'b1, 7'd12, 2'd1, 1'b1, "R9 same-cycle write");
    ticks(4, 2'b11, "R9 write seen next slot");

    ticks(6, 2'b10, "R5 1:3 scan");
    ticks(4, 2'b01, "R6 1:2 scan");
    ticks(3, 2'b11, "R2 back to 1:4");
    ticks(1, 2'b01, "R11 shrink mid-frame");
    ticks(2, 2'b11, "R2 regrow");
    ticks(1, 2'b00, "R11 to static");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] md;
      md = ($urandom % 16 == 0) ? 2'($urandom) : mode;
      cyc(($urandom % 3) == 0, md, $urandom % 2, 7'($urandom), 2'($urandom),
          1'($urandom), "R2 R3 R8 random");
    end

    @(negedge clk);
    tick = 1'b0; wr = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule